// File: doc/BRIEF.md
# Retirement Register Alias Table

This block holds the committed rename map of an out-of-order core: for every architectural register it records which physical tag currently holds its retired value. Retirement logic talks to it through a parameter-chosen number of ports (1, 2 or 4). Each port does one of two things per cycle. A commit installs a new physical tag for a logical register and hands back the tag it replaced, so the caller can return that tag to the free pool. A peek reads the tag a logical register is mapped to and leaves the table untouched.

Both operations return the old tag combinationally, in the cycle the request is accepted, read from the table as it stood before that cycle's writes. All commits accepted in a cycle update the table together at the clock edge. The table has no reset of its own. After reset the block writes tag zero into one entry per cycle, and all port readies stay low until every entry has been cleared. Logical register zero is hard-wired to physical tag zero. The caller must never present, in one cycle, two active ports that name the same logical register.

Top module: `retire_alias_table`

## Requirements
- R1: While reset is asserted, and for exactly NUM_ARCH clock cycles after it is released, every bit of `port_ready` is 0. From then on every bit is 1 and stays 1 until the next reset.
- R2: Once the clear has finished, a peek of any logical register returns tag 0 until some commit writes that register.
- R3: A commit (op bit = 1) that is accepted returns, in the same cycle, the tag the register held before the commit.
- R4: The tag written by an accepted commit is returned by any operation on that register from the next cycle on.
- R5: A peek (op bit = 0) returns the current tag and leaves the table unchanged, so peeks repeated on the same register return the same value.
- R6: A commit to logical register 0 returns tag 0 and leaves that register at tag 0.
- R7: Commits accepted on several ports in one cycle, each to a different register, all take effect at the same clock edge. Each returns the tag from before that edge.
- R8: A request presented while readies are low changes nothing in the table and returns tag 0.
- R9: A port without an accepted request (valid low, or ready low) drives `port_old_tag` 0 on its field.
- R10: Ports are independent. Port p returns only the result of its own request, in field p of `port_old_tag` (bits p*TAG_W upward), whatever mix of operations the other ports carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the table clear |
| port_valid | input | NUM_PORTS | Per-port request valid, bit p belongs to port p |
| port_ready | output | NUM_PORTS | Per-port ready; low while the clear runs |
| port_op | input | NUM_PORTS | Per-port operation: 1 = commit, 0 = peek |
| port_idx | input | NUM_PORTS*IDX_W | Logical register of port p at bits p*IDX_W upward |
| port_tag | input | NUM_PORTS*TAG_W | New physical tag for a commit, field p at bits p*TAG_W upward |
| port_old_tag | output | NUM_PORTS*TAG_W | Tag that was mapped before this cycle, field p per port |

## Verification
The bench times the post-reset clear to the exact cycle. A clear that is one cycle short or long, or a ready raised on only some ports, shows up as a wrong count. It sends a commit while the readies are low and later peeks that register: a design that accepted the request would return the stored tag instead of zero. Four-port commit rounds to distinct registers catch a design whose ports write in sequence or forward each other's new tags, because the returned old tags would then be wrong. Commits to register zero catch a table that stores a nonzero tag there, and peeks repeated on the same register catch a peek that writes.

// File: rtl/rat_pkg.sv
// Package: shared operation encoding for the retirement alias table.
// Assumes: one select bit per port; 1 selects commit, 0 selects peek.
package rat_pkg;
    typedef enum logic {
        OP_PEEK   = 1'b0,
        OP_COMMIT = 1'b1
    } rat_op_e;
endpackage

// File: rtl/rat_clear_seq.sv
// Module: post-reset clear sequencer. Steps an index across every table
// entry, one per cycle, then raises a done flag that stays high until reset.
// Assumes: NUM_ARCH >= 2 and the index width covers NUM_ARCH - 1.
module rat_clear_seq #(
    parameter int NUM_ARCH = 32,
    parameter int IDX_W    = $clog2(NUM_ARCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ARCH - 1);

    logic [IDX_W-1:0] cnt_q;
    logic             done_q;

    // Move the clear index forward until the last entry has been written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Present the clear write while the sequence is still running.
    always_comb begin
        clr_en  = !done_q;
        clr_idx = cnt_q;
        done    = done_q;
    end
endmodule

// File: rtl/rat_map_store.sv
// Module: tag storage. Has one combinational read per port and one write per
// port; all writes land at the same clock edge. A clear write has priority.
// Assumes: the write indices enabled in one cycle are distinct, and
// NUM_ARCH is a power of two so that every index is in range.
module rat_map_store #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_ARCH  = 32,
    parameter int TAG_W     = 5,
    parameter int IDX_W     = $clog2(NUM_ARCH)
) (
    input  logic                       clk,
    input  logic                       clr_en,
    input  logic [IDX_W-1:0]           clr_idx,
    input  logic [NUM_PORTS-1:0]       wr_en,
    input  logic [NUM_PORTS*IDX_W-1:0] wr_idx,
    input  logic [NUM_PORTS*TAG_W-1:0] wr_tag,
    input  logic [NUM_PORTS*IDX_W-1:0] rd_idx,
    output logic [NUM_PORTS*TAG_W-1:0] rd_tag
);
    logic [TAG_W-1:0] mem [NUM_ARCH];

    // Write either the clear zero or the enabled port tags.
    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_idx] <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (wr_en[p]) begin
                    mem[wr_idx[p*IDX_W +: IDX_W]] <= wr_tag[p*TAG_W +: TAG_W];
                end
            end
        end
    end

    // Read each port's entry from the state before this cycle's writes.
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            rd_tag[p*TAG_W +: TAG_W] = mem[rd_idx[p*IDX_W +: IDX_W]];
        end
    end
endmodule

// File: rtl/rat_port_ctrl.sv
// Module: per-port handshake and operation decode. Accepts a request once
// the clear is done, turns a commit into a write enable (never for register
// zero), and returns the stored tag only for an accepted request.
// Assumes: the tag read is combinational from the storage.
module rat_port_ctrl
    import rat_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int IDX_W = 5
) (
    input  logic             done,
    input  logic             valid,
    input  logic             op,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             ready,
    output logic             wr_en,
    output logic [TAG_W-1:0] old_tag
);
    logic fire;

    // Gate the request by the clear flag and decode the operation.
    always_comb begin
        ready   = done;
        fire    = valid && done;
        wr_en   = fire && (op == OP_COMMIT) && (idx != '0);
        old_tag = fire ? rd_tag : '0;
    end
endmodule

// File: rtl/retire_alias_table.sv
// Module: multi-port retirement register alias table (top). Wires the clear
// sequencer, the storage and one port controller per retirement port.
// Assumes: active ports in a cycle name distinct registers; NUM_ARCH is a
// power of two; NUM_PORTS is 1, 2 or 4.
module retire_alias_table #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_ARCH  = 32,
    parameter int TAG_W     = 5,
    parameter int IDX_W     = $clog2(NUM_ARCH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       port_valid,
    output logic [NUM_PORTS-1:0]       port_ready,
    input  logic [NUM_PORTS-1:0]       port_op,
    input  logic [NUM_PORTS*IDX_W-1:0] port_idx,
    input  logic [NUM_PORTS*TAG_W-1:0] port_tag,
    output logic [NUM_PORTS*TAG_W-1:0] port_old_tag
);
    logic                       clr_en;
    logic [IDX_W-1:0]           clr_idx;
    logic                       done;
    logic [NUM_PORTS-1:0]       wr_en;
    logic [NUM_PORTS*TAG_W-1:0] rd_tag;

    rat_clear_seq #(.NUM_ARCH(NUM_ARCH), .IDX_W(IDX_W)) u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .done    (done)
    );

    rat_map_store #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_ARCH  (NUM_ARCH),
        .TAG_W     (TAG_W),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .wr_en   (wr_en),
        .wr_idx  (port_idx),
        .wr_tag  (port_tag),
        .rd_idx  (port_idx),
        .rd_tag  (rd_tag)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rat_port_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_port (
            .done    (done),
            .valid   (port_valid[p]),
            .op      (port_op[p]),
            .idx     (port_idx[p*IDX_W +: IDX_W]),
            .rd_tag  (rd_tag[p*TAG_W +: TAG_W]),
            .ready   (port_ready[p]),
            .wr_en   (wr_en[p]),
            .old_tag (port_old_tag[p*TAG_W +: TAG_W])
        );
    end
endmodule

// File: rtl/rat_checker.sv
// Module: assertion checker bound to the alias table top. It sees only the
// top ports.
module rat_checker #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_ARCH  = 32,
    parameter int TAG_W     = 5,
    parameter int IDX_W     = $clog2(NUM_ARCH)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_PORTS-1:0]       port_valid,
    input logic [NUM_PORTS-1:0]       port_ready,
    input logic [NUM_PORTS*IDX_W-1:0] port_idx,
    input logic [NUM_PORTS*TAG_W-1:0] port_old_tag
);
    int unsigned low_cnt;

    // Count the cycles since reset during which the readies have stayed low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (port_ready == '0) begin
            low_cnt <= low_cnt + 1;
        end
    end

    // R1
    ready_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_ready == '0) || (port_ready == '1));

    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_ready[0] |=> port_ready[0]);

    // R1
    clear_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_ready == '0) |-> (low_cnt < NUM_ARCH));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R9
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(port_valid[p] && port_ready[p]) |-> (port_old_tag[p*TAG_W +: TAG_W] == '0));

        // R6
        zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (port_idx[p*IDX_W +: IDX_W] == '0) |-> (port_old_tag[p*TAG_W +: TAG_W] == '0));

        for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
            // R7
            distinct_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (port_valid[p] && port_valid[q] && port_ready[p])
                |-> (port_idx[p*IDX_W +: IDX_W] != port_idx[q*IDX_W +: IDX_W]));
        end
    end
endmodule

bind retire_alias_table rat_checker #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_ARCH  (NUM_ARCH),
    .TAG_W     (TAG_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_valid   (port_valid),
    .port_ready   (port_ready),
    .port_idx     (port_idx),
    .port_old_tag (port_old_tag)
);

// File: tb/retire_alias_table_tb.sv
`timescale 1ns/1ps
module retire_alias_table_tb;
    localparam int NP = 4;
    localparam int NA = 32;
    localparam int TW = 5;
    localparam int IW = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    port_valid = '0;
    logic [NP-1:0]    port_ready;
    logic [NP-1:0]    port_op = '0;
    logic [NP*IW-1:0] port_idx = '0;
    logic [NP*TW-1:0] port_tag = '0;
    logic [NP*TW-1:0] port_old_tag;

    retire_alias_table #(.NUM_PORTS(NP), .NUM_ARCH(NA), .TAG_W(TW), .IDX_W(IW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_valid   (port_valid),
        .port_ready   (port_ready),
        .port_op      (port_op),
        .port_idx     (port_idx),
        .port_tag     (port_tag),
        .port_old_tag (port_old_tag)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          port;
        logic [TW-1:0] exp;
        string       rq;
    } item_t;

    item_t         sbq[$];
    logic [TW-1:0] model [NA];
    int            d_idx [NP];
    int            d_tag [NP];
    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Driver: drive one cycle, queue the expected old tags, then update the model.
    task automatic issue(input logic [NP-1:0] v, input logic [NP-1:0] cm,
                         input bit rdy, input string rq);
        item_t it;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            port_valid[p] = v[p];
            port_op[p]    = cm[p];
            port_idx[p*IW +: IW] = IW'(d_idx[p]);
            port_tag[p*TW +: TW] = TW'(d_tag[p]);
            it.port = p;
            it.exp  = (v[p] && rdy) ? model[d_idx[p]] : '0;
            it.rq   = rq;
            sbq.push_back(it);
        end
        for (int p = 0; p < NP; p++) begin
            if (v[p] && rdy && cm[p] && d_idx[p] != 0) model[d_idx[p]] = TW'(d_tag[p]);
        end
    endtask

    // Monitor: compare every queued expectation against the outputs.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #5;
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                chk(port_old_tag[it.port*TW +: TW] == it.exp, it.rq,
                    int'(port_old_tag[it.port*TW +: TW]), int'(it.exp));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int nclr;
        int base;
        logic [NP-1:0] v;
        logic [NP-1:0] cm;
        for (int i = 0; i < NA; i++) model[i] = '0;
        for (int p = 0; p < NP; p++) begin d_idx[p] = 0; d_tag[p] = 0; end

        // R1: reset state
        repeat (3) @(negedge clk);
        #6 chk(port_ready == '0, "R1 reset", int'(port_ready), 0);

        // R1 clear length, R8 request during clear, R9 idle ports
        @(negedge clk);
        rst_n = 1'b1;
        nclr = 0;
        forever begin
            #6;
            if (port_ready != '0) break;
            nclr++;
            if (nclr == 10) begin
                d_idx[0] = 5; d_tag[0] = 9;
                issue(4'b0001, 4'b0001, 1'b0, "R8");
            end else begin
                issue('0, '0, 1'b0, "R9");
            end
        end
        chk(nclr == NA, "R1 clear cycles", nclr, NA);
        chk(port_ready == '1, "R1 ready", int'(port_ready), (1 << NP) - 1);

        // R2: every entry reads zero after clear (entry 5 proves R8 left it alone)
        for (int b = 0; b < NA / NP; b++) begin
            for (int p = 0; p < NP; p++) d_idx[p] = b * NP + p;
            issue('1, '0, 1'b1, "R2");
        end

        // R3 R7: rounds of four simultaneous commits to distinct registers
        for (int r = 0; r < 24; r++) begin
            base = $urandom_range(0, NA - 1);
            for (int p = 0; p < NP; p++) begin
                d_idx[p] = (base + p * 8) % NA;
                d_tag[p] = $urandom_range(1, (1 << TW) - 1);
            end
            issue('1, '1, 1'b1, "R3 R7");
        end

        // R4: new tag visible next cycle; R5: peeks do not modify
        for (int p = 0; p < NP; p++) begin d_idx[p] = p + 1; d_tag[p] = 20 + p; end
        issue('1, '1, 1'b1, "R3");
        issue('1, '0, 1'b1, "R4");
        issue('1, '0, 1'b1, "R5");
        issue('1, '0, 1'b1, "R5");

        // R6: commit to register zero
        d_idx[0] = 0; d_tag[0] = 17;
        issue(4'b0001, 4'b0001, 1'b1, "R6");
        issue(4'b0001, 4'b0000, 1'b1, "R6");

        // R10: random mixes of op and valid per port; R9 on idle ports
        for (int r = 0; r < 40; r++) begin
            base = $urandom_range(0, NA - 1);
            v  = NP'($urandom_range(0, (1 << NP) - 1));
            cm = NP'($urandom_range(0, (1 << NP) - 1));
            for (int p = 0; p < NP; p++) begin
                d_idx[p] = (base + p * 8) % NA;
                d_tag[p] = $urandom_range(0, (1 << TW) - 1);
            end
            issue(v, cm, 1'b1, "R10");
        end

        issue('0, '0, 1'b1, "R9");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule